// File: doc/BRIEF.md
# Stack Pointer with Bounds Guard

This block keeps the pointer of a word-wide system stack that lives in on-chip data RAM. On each push or pop it supplies the RAM byte address for the access and steps the pointer by one word. Each such access is checked against two limit registers that software writes: a low-water mark for overflow and a high-water mark for underflow. The stack grows toward lower addresses. A push decrements the pointer before it is used, and a pop uses the pointer and then increments it.

When an access crosses a limit, a sticky trap flag is raised for the trap logic. The access that crossed the limit still completes. The flags stay set until software clears them through a dedicated clear input. The pointer and both limits are always word-aligned. Reset places the pointer at the top of the stack region, the overflow limit at the region base and the underflow limit at the region top. The RAM array, the trap vectoring and the instruction decode sit outside the block.

Top module: `stack_ptr_guard`

## Requirements
- R1: After reset, `sp_o` equals the region top (REGION_BASE + REGION_BYTES, default 16'hFA00), both trap flags are 0, and with no request `ram_addr_o` equals `sp_o`.
- R2: A push alone (`push_i`=1, `pop_i`=0, `sp_we_i`=0) drives `ram_addr_o` = `sp_o` − 2 in the same cycle, and `sp_o` takes that value after the clock edge. Arithmetic is modulo 2^ADDR_W.
- R3: A pop alone drives `ram_addr_o` = `sp_o` in the same cycle, and `sp_o` becomes `sp_o` + 2 after the clock edge.
- R4: When `push_i` and `pop_i` are both 1 in a cycle, neither is performed: the pointer and the flags keep their values, and `ram_addr_o` = `sp_o`.
- R5: A pointer write loads `sp_wdata_i` with bit 0 forced to 0. It takes precedence over a push or pop in the same cycle, and that push or pop is dropped.
- R6: A push whose new pointer is below the overflow limit (unsigned compare) sets `ovf_trap_o` one cycle later. The pointer is still updated.
- R7: A pop whose new pointer is above the underflow limit (unsigned compare) sets `unf_trap_o` one cycle later. The pointer is still updated.
- R8: A write to either limit stores the data with bit 0 forced to 0. The new limit applies to accesses from the next cycle onward. An access in the same cycle as the write compares against the old limit.
- R9: The trap flags are sticky. `trap_clr_i[0]` clears `ovf_trap_o` and `trap_clr_i[1]` clears `unf_trap_o`. A new trap in the same cycle as a clear leaves the flag set.
- R10: With the reset limits, REGION_BYTES/2 pushes from reset raise no overflow and the next push does. A pop straight after reset raises an underflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_i | input | 1 | Push request this cycle |
| pop_i | input | 1 | Pop request this cycle |
| sp_we_i | input | 1 | Stack pointer write enable |
| sp_wdata_i | input | ADDR_W | Stack pointer write data |
| ovl_we_i | input | 1 | Overflow limit write enable |
| ovl_wdata_i | input | ADDR_W | Overflow limit write data |
| unl_we_i | input | 1 | Underflow limit write enable |
| unl_wdata_i | input | ADDR_W | Underflow limit write data |
| trap_clr_i | input | 2 | Flag clear: bit 0 overflow, bit 1 underflow |
| ram_addr_o | output | ADDR_W | Byte address of the current stack access |
| sp_o | output | ADDR_W | Current stack pointer |
| ovf_trap_o | output | 1 | Sticky overflow trap flag |
| unf_trap_o | output | 1 | Sticky underflow trap flag |

## Verification
`ram_addr_o` is combinational, so the bench samples it 1 ns after driving the inputs, within the same cycle as the request. The pointer and both trap flags are registered once. They are sampled 1 ns after the next rising edge, which means every request is judged exactly one edge later. Limit writes never appear on a port. The bench observes them through the flag result of the first access after the write, and also the flag result of an access in the same cycle as the write, which must still use the old limit.

// File: rtl/spg_pkg.sv
package spg_pkg;
   typedef enum logic [1:0] {
      OP_IDLE = 2'd0,
      OP_PUSH = 2'd1,
      OP_POP  = 2'd2
   } spg_op_e;

   localparam int unsigned LIM_OVF = 0;
   localparam int unsigned LIM_UNF = 1;
   localparam int unsigned NUM_LIM = 2;

   function automatic spg_op_e spg_decode(input logic push, input logic pop, input logic wr);
      if (wr || (push && pop)) return OP_IDLE;
      if (push)                return OP_PUSH;
      if (pop)                 return OP_POP;
      return OP_IDLE;
   endfunction
endpackage

// File: rtl/spg_ptr_unit.sv
module spg_ptr_unit
   import spg_pkg::*;
#(
   parameter int unsigned ADDR_W   = 16,
   parameter int unsigned STEP     = 2,
   parameter logic [ADDR_W-1:0] RESET_SP = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  spg_op_e           op,
   input  logic              wr,
   input  logic [ADDR_W-1:0] wdata,
   output logic [ADDR_W-1:0] sp_q,
   output logic [ADDR_W-1:0] sp_next,
   output logic [ADDR_W-1:0] addr
);
   localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);
   localparam logic [ADDR_W-1:0] ALIGN  = ~ADDR_W'(STEP - 1);

   logic [ADDR_W-1:0] dec_v;
   logic [ADDR_W-1:0] inc_v;

   assign dec_v = sp_q - STEP_V;
   assign inc_v = sp_q + STEP_V;

   always_comb begin
      unique case (op)
         OP_PUSH: sp_next = dec_v;
         OP_POP:  sp_next = inc_v;
         default: sp_next = sp_q;
      endcase
   end

   assign addr = (op == OP_PUSH) ? dec_v : sp_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   sp_q <= RESET_SP;
      else if (wr)  sp_q <= wdata & ALIGN;
      else          sp_q <= sp_next;
   end

   // R2
   push_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_PUSH) |=> (sp_q == $past(sp_q) - STEP_V));
   // R3
   pop_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_POP) |=> (sp_q == $past(sp_q) + STEP_V));
   // R4
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_IDLE && !wr) |=> $stable(sp_q));
   // R5
   sp_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr |=> (sp_q[0] == 1'b0));
endmodule

// File: rtl/spg_limit_regs.sv
module spg_limit_regs
   import spg_pkg::*;
#(
   parameter int unsigned ADDR_W = 16,
   parameter logic [ADDR_W-1:0] RESET_OVF = '0,
   parameter logic [ADDR_W-1:0] RESET_UNF = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_LIM-1:0] we,
   input  logic [ADDR_W-1:0] wdata [NUM_LIM],
   output logic [ADDR_W-1:0] lim   [NUM_LIM]
);
   localparam logic [ADDR_W-1:0] ALIGN = ~ADDR_W'(1);

   for (genvar g = 0; g < NUM_LIM; g++) begin : g_lim
      localparam logic [ADDR_W-1:0] INIT = (g == LIM_OVF) ? RESET_OVF : RESET_UNF;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     lim[g] <= INIT;
         else if (we[g]) lim[g] <= wdata[g] & ALIGN;
      end

      // R8
      lim_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
         we[g] |=> (lim[g] == ($past(wdata[g]) & ALIGN)));
   end
endmodule

// File: rtl/spg_trap_flags.sv
module spg_trap_flags
   import spg_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_LIM-1:0] hit,
   input  logic [NUM_LIM-1:0] clr,
   output logic [NUM_LIM-1:0] flag
);
   for (genvar g = 0; g < NUM_LIM; g++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       flag[g] <= 1'b0;
         else if (hit[g])  flag[g] <= 1'b1;
         else if (clr[g])  flag[g] <= 1'b0;
      end

      // R9
      flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (flag[g] && !clr[g]) |=> flag[g]);
      // R9
      flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (clr[g] && !hit[g]) |=> !flag[g]);
   end
endmodule

// File: rtl/stack_ptr_guard.sv
module stack_ptr_guard
   import spg_pkg::*;
#(
   parameter int unsigned ADDR_W       = 16,
   parameter int unsigned REGION_BASE  = 32'hF600,
   parameter int unsigned REGION_BYTES = 1024
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push_i,
   input  logic              pop_i,
   input  logic              sp_we_i,
   input  logic [ADDR_W-1:0] sp_wdata_i,
   input  logic              ovl_we_i,
   input  logic [ADDR_W-1:0] ovl_wdata_i,
   input  logic              unl_we_i,
   input  logic [ADDR_W-1:0] unl_wdata_i,
   input  logic [1:0]        trap_clr_i,
   output logic [ADDR_W-1:0] ram_addr_o,
   output logic [ADDR_W-1:0] sp_o,
   output logic              ovf_trap_o,
   output logic              unf_trap_o
);
   localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(REGION_BASE);
   localparam logic [ADDR_W-1:0] TOP_A  = ADDR_W'(REGION_BASE + REGION_BYTES);

   if (ADDR_W < 4 || ADDR_W > 32) begin : g_bad_aw
      $error("stack_ptr_guard: ADDR_W out of range");
   end
   if (REGION_BYTES < 2 || REGION_BYTES > 1024 || (REGION_BYTES % 2) != 0) begin : g_bad_size
      $error("stack_ptr_guard: REGION_BYTES must be even and 2..1024");
   end
   if ((REGION_BASE % 2) != 0) begin : g_bad_base
      $error("stack_ptr_guard: REGION_BASE must be word aligned");
   end
   if (64'(REGION_BASE) + 64'(REGION_BYTES) > (64'd1 << ADDR_W)) begin : g_bad_fit
      $error("stack_ptr_guard: region exceeds address space");
   end

   spg_op_e           op;
   logic [ADDR_W-1:0] sp_q, sp_next;
   logic [ADDR_W-1:0] lim_wd [NUM_LIM];
   logic [ADDR_W-1:0] lim    [NUM_LIM];
   logic [NUM_LIM-1:0] lim_we, hit, flag;

   assign op = spg_decode(push_i, pop_i, sp_we_i);

   spg_ptr_unit #(
      .ADDR_W   (ADDR_W),
      .STEP     (2),
      .RESET_SP (TOP_A)
   ) u_ptr (
      .clk     (clk),
      .rst_n   (rst_n),
      .op      (op),
      .wr      (sp_we_i),
      .wdata   (sp_wdata_i),
      .sp_q    (sp_q),
      .sp_next (sp_next),
      .addr    (ram_addr_o)
   );

   assign lim_we[LIM_OVF] = ovl_we_i;
   assign lim_we[LIM_UNF] = unl_we_i;
   assign lim_wd[LIM_OVF] = ovl_wdata_i;
   assign lim_wd[LIM_UNF] = unl_wdata_i;

   spg_limit_regs #(
      .ADDR_W    (ADDR_W),
      .RESET_OVF (BASE_A),
      .RESET_UNF (TOP_A)
   ) u_lim (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (lim_we),
      .wdata (lim_wd),
      .lim   (lim)
   );

   assign hit[LIM_OVF] = (op == OP_PUSH) && (sp_next < lim[LIM_OVF]);
   assign hit[LIM_UNF] = (op == OP_POP)  && (sp_next > lim[LIM_UNF]);

   spg_trap_flags u_flags (
      .clk   (clk),
      .rst_n (rst_n),
      .hit   (hit),
      .clr   (trap_clr_i),
      .flag  (flag)
   );

   assign sp_o       = sp_q;
   assign ovf_trap_o = flag[LIM_OVF];
   assign unf_trap_o = flag[LIM_UNF];

   // R6
   ovf_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push_i && !pop_i && !sp_we_i && (ram_addr_o < lim[LIM_OVF])) |=> ovf_trap_o);
   // R7
   unf_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_i && !push_i && !sp_we_i && (ram_addr_o + ADDR_W'(2) > lim[LIM_UNF])) |=> unf_trap_o);
   // R2
   push_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push_i && !pop_i && !sp_we_i) |=> (sp_o == $past(ram_addr_o)));
endmodule

// File: tb/stack_ptr_guard_bench.sv
module stack_ptr_guard_bench;
   localparam int unsigned AW    = 16;
   localparam int unsigned BASE  = 32'hF600;
   localparam int unsigned BYTES = 1024;
   localparam logic [AW-1:0] TOP_A  = AW'(BASE + BYTES);
   localparam logic [AW-1:0] BASE_A = AW'(BASE);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          push_i = 0, pop_i = 0, sp_we_i = 0, ovl_we_i = 0, unl_we_i = 0;
   logic [AW-1:0] sp_wdata_i = '0, ovl_wdata_i = '0, unl_wdata_i = '0;
   logic [1:0]    trap_clr_i = '0;
   logic [AW-1:0] ram_addr_o, sp_o;
   logic          ovf_trap_o, unf_trap_o;

   int unsigned n_chk = 0;
   int unsigned n_fail = 0;

   logic [AW-1:0] m_sp, m_ovl, m_unl;
   logic          m_ovf, m_unf;

   always #5 clk = ~clk;

   stack_ptr_guard #(.ADDR_W(AW), .REGION_BASE(BASE), .REGION_BYTES(BYTES)) u_stack_ptr_guard (
      .clk, .rst_n, .push_i, .pop_i, .sp_we_i, .sp_wdata_i, .ovl_we_i, .ovl_wdata_i,
      .unl_we_i, .unl_wdata_i, .trap_clr_i, .ram_addr_o, .sp_o, .ovf_trap_o, .unf_trap_o
   );

   task automatic check(input string tag, input string what, input logic [AW-1:0] act, input logic [AW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   function automatic logic [AW-1:0] exp_addr(input logic p, input logic q, input logic w, input logic [AW-1:0] sp);
      return (p && !q && !w) ? sp - AW'(2) : sp;
   endfunction

   // Drive at falling edge; returns at the next falling edge.
   task automatic step(input logic p, input logic q, input logic w, input logic [AW-1:0] wd,
                       input logic ow, input logic [AW-1:0] od, input logic uw, input logic [AW-1:0] ud,
                       input logic [1:0] clr, input string tag);
      logic do_push, do_pop;
      logic [AW-1:0] nsp;
      push_i = p; pop_i = q; sp_we_i = w; sp_wdata_i = wd;
      ovl_we_i = ow; ovl_wdata_i = od; unl_we_i = uw; unl_wdata_i = ud; trap_clr_i = clr;
      #1;
      check(tag, "ram_addr", ram_addr_o, exp_addr(p, q, w, m_sp));
      do_push = p && !q && !w;
      do_pop  = q && !p && !w;
      nsp = w ? (wd & ~AW'(1)) : do_push ? m_sp - AW'(2) : do_pop ? m_sp + AW'(2) : m_sp;
      m_ovf = (do_push && (nsp < m_ovl)) ? 1'b1 : (clr[0] ? 1'b0 : m_ovf);
      m_unf = (do_pop  && (nsp > m_unl)) ? 1'b1 : (clr[1] ? 1'b0 : m_unf);
      m_sp = nsp;
      if (ow) m_ovl = od & ~AW'(1);
      if (uw) m_unl = ud & ~AW'(1);
      @(posedge clk); #1;
      check(tag, "sp", sp_o, m_sp);
      check(tag, "ovf", AW'(ovf_trap_o), AW'(m_ovf));
      check(tag, "unf", AW'(unf_trap_o), AW'(m_unf));
      @(negedge clk);
   endtask

   task automatic op(input logic p, input logic q, input string tag);
      step(p, q, 0, '0, 0, '0, 0, '0, 2'b00, tag);
   endtask

   function automatic logic [AW-1:0] rnd_in_region();
      return BASE_A + AW'($urandom % (BYTES + 1));
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      m_sp = TOP_A; m_ovl = BASE_A; m_unl = TOP_A; m_ovf = 0; m_unf = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1", "sp", sp_o, TOP_A);
      check("R1", "ovf", AW'(ovf_trap_o), '0);
      check("R1", "unf", AW'(unf_trap_o), '0);
      check("R1", "ram_addr", ram_addr_o, TOP_A);
      // R10 pop from empty underflows; R3 pointer moves up
      op(0, 1, "R10");
      // R9 clear underflow; R5 aligned pointer write
      step(0, 0, 1, TOP_A | AW'(1), 0, '0, 0, '0, 2'b10, "R9");
      check("R5", "sp_aligned", sp_o, TOP_A);
      // R10 fill region exactly: no overflow
      for (int i = 0; i < BYTES / 2; i++) op(1, 0, "R10");
      check("R10", "ovf_after_fill", AW'(ovf_trap_o), '0);
      // R6 one more push overflows and still completes
      op(1, 0, "R6");
      check("R6", "sp_completed", sp_o, BASE_A - AW'(2));
      // R9 sticky across idle and pops
      op(0, 0, "R9");
      op(0, 1, "R9");
      // R9 set wins over clear
      step(1, 0, 0, '0, 0, '0, 0, '0, 2'b01, "R9");
      check("R9", "set_beats_clr", AW'(ovf_trap_o), AW'(1));
      step(0, 0, 0, '0, 0, '0, 0, '0, 2'b01, "R9");
      // R4 push and pop together
      op(1, 1, "R4");
      // R5 write beats push
      step(1, 0, 1, TOP_A, 0, '0, 0, '0, 2'b00, "R5");
      // R8 odd limit write, same-cycle access uses old limit
      step(1, 0, 0, '0, 1, (TOP_A - AW'(4)) | AW'(1), 0, '0, 2'b00, "R8");
      op(1, 0, "R8");
      check("R8", "no_ovf_at_limit", AW'(ovf_trap_o), '0);
      op(1, 0, "R8");
      check("R8", "ovf_below_limit", AW'(ovf_trap_o), AW'(1));
      // R8 underflow limit odd write
      step(0, 0, 1, TOP_A - AW'(4), 0, '0, 1, (TOP_A - AW'(2)) | AW'(1), 2'b11, "R8");
      op(0, 1, "R8");
      op(0, 1, "R7");
      check("R7", "unf_above_limit", AW'(unf_trap_o), AW'(1));
      // restore region limits, then random traffic
      step(0, 0, 1, TOP_A, 1, BASE_A, 1, TOP_A, 2'b11, "R8");
      for (int i = 0; i < 4000; i++) begin
         int unsigned r = $urandom % 100;
         logic [1:0] c = ($urandom % 8 == 0) ? 2'($urandom) : 2'b00;
         if (r < 42)      step(1, 0, 0, '0, 0, '0, 0, '0, c, "R2");
         else if (r < 84) step(0, 1, 0, '0, 0, '0, 0, '0, c, "R3");
         else if (r < 88) step(1, 1, 0, '0, 0, '0, 0, '0, c, "R4");
         else if (r < 92) step($urandom % 2 == 1, 0, 1, rnd_in_region() | AW'($urandom % 2), 0, '0, 0, '0, c, "R5");
         else if (r < 95) step($urandom % 2 == 1, 0, 0, '0, 1, rnd_in_region() | AW'($urandom % 2), 0, '0, c, "R6");
         else if (r < 98) step(0, $urandom % 2 == 1, 0, '0, 0, '0, 1, rnd_in_region() | AW'($urandom % 2), c, "R7");
         else             step(0, 0, 0, '0, 0, '0, 0, '0, 2'($urandom), "R9");
      end
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule